// File: doc/BRIEF.md
# Shared Bus Arbiter with Selectable Grant Scheme

This block decides which of four attached devices may drive a shared bus. Three grant schemes are built in, and the one in use is fixed at reset. In the chained-token scheme a bus-available token enters at device 0 and passes down the devices in index order. Each device that does not want the bus passes the token on. The first requesting device keeps the token, and it holds the grant for as long as it has the token. In the address-scan scheme the arbiter steps a broadcast address through the devices. A device that sees its own address claims the bus. In the central-ranking scheme every device raises its own request line, and the arbiter grants the pending request with the lowest index.

All three schemes end the same way. The winning device drives the shared busy line high while it owns the bus and drops it to release the bus. The arbiter never issues a grant, and never advances the scan, while busy is high. The data transfer on the bus is not part of this block.

Top module: `bus_arbiter`

## Requirements
- R1: The scheme is taken from `mode_sel` while reset is active and stays fixed until the next reset. The encodings are 2'b00 for chained token, 2'b01 for address scan, 2'b10 for central ranking, and 2'b11 also selects chained token. A change of `mode_sel` after reset has no effect.
- R2: In chained-token mode with busy low, `dev_grant` is, in the same cycle, the one-hot bit of the requesting device with the lowest index. Bit i belongs to device i, and device 0 ranks first.
- R3: In chained-token mode, busy high withholds the token from every device, so `dev_grant` is zero.
- R4: In central-ranking mode, when busy is low and no grant is held, the clock edge after a request is seen sets `dev_grant` to the one-hot bit of the lowest-index requester.
- R5: In central-ranking mode, `dev_grant` is zero from the first edge that sees busy high, and no new grant is issued while busy stays high.
- R6: In address-scan mode, when busy is low and the addressed device is not requesting, `poll_addr` advances by one on every clock and wraps from 3 to 0.
- R7: In address-scan mode, the scan stops on an address whose device is requesting, and `poll_valid` stays high there.
- R8: In address-scan mode, busy high drives `poll_valid` low and freezes `poll_addr`. On the first edge after busy drops, the scan moves on to the next address.
- R9: At most one bit of `dev_grant` is ever high, and `dev_grant` is zero in address-scan mode.
- R10: While reset is active, `dev_grant` is zero, `poll_valid` is low and `poll_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Scheme select, sampled during reset |
| dev_req | input | 4 | Request line from each device |
| bus_busy | input | 1 | Shared busy line, driven by the bus owner |
| dev_grant | output | 4 | One-hot grant (chained-token and central-ranking modes) |
| poll_addr | output | 2 | Broadcast scan address |
| poll_valid | output | 1 | Broadcast address is live and may be claimed |

## Verification
Each scheme has its own result latency.

- **Chained token:** the grant follows `dev_req` and `bus_busy` in the same cycle. The bench drives at the falling edge and samples 1 ns later.
- **Central ranking:** the grant appears one rising edge after the request or the busy change, so the bench samples at the next falling edge.
- **Address scan:** the address moves one step per rising edge, so the bench samples once per falling edge. The resumed address is due one edge after busy falls.
- **Mode lock:** the R1 check samples 1 ns after `mode_sel` changes. At that moment a chained-token reading would already show a grant, while the locked mode shows none.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;
  typedef enum logic [1:0] {
    SCH_CHAIN = 2'b00,
    SCH_SCAN  = 2'b01,
    SCH_RANK  = 2'b10
  } scheme_e;

  function automatic scheme_e decode_scheme(input logic [1:0] sel);
    case (sel)
      2'b01:   return SCH_SCAN;
      2'b10:   return SCH_RANK;
      default: return SCH_CHAIN;
    endcase
  endfunction
endpackage

// File: rtl/arb_token_chain.sv
module arb_token_chain #(
  parameter int N_DEV = 4
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             en,
  input  logic             busy,
  input  logic [N_DEV-1:0] req,
  output logic [N_DEV-1:0] grant
);
  logic token;

  always_comb begin
    token = en & ~busy;
    for (int i = 0; i < N_DEV; i++) begin
      grant[i] = token & req[i];
      token    = token & ~req[i];
    end
  end

  p_busy_blocks_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    busy |-> (grant == '0));

  for (genvar g = 0; g < N_DEV; g++) begin : g_chk
    p_grant_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_ni)
      grant[g] |-> req[g]);
  end
endmodule

// File: rtl/arb_addr_scan.sv
module arb_addr_scan #(
  parameter int N_DEV = 4,
  localparam int AW   = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             en,
  input  logic             busy,
  input  logic [N_DEV-1:0] req,
  output logic [AW-1:0]    addr,
  output logic             valid
);
  localparam logic [AW-1:0] LAST = AW'(N_DEV - 1);

  logic [AW-1:0] addr_q, addr_d, addr_inc;
  logic          claim_q, claim_d;

  assign addr_inc = (addr_q == LAST) ? '0 : addr_q + AW'(1);

  always_comb begin
    addr_d  = addr_q;
    claim_d = claim_q;
    if (en) begin
      if (busy) begin
        claim_d = 1'b1;
      end else if (claim_q) begin
        addr_d  = addr_inc;
        claim_d = 1'b0;
      end else if (!req[addr_q]) begin
        addr_d = addr_inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      claim_q <= 1'b0;
    end else begin
      addr_q  <= addr_d;
      claim_q <= claim_d;
    end
  end

  assign addr  = addr_q;
  assign valid = en & ~busy & ~claim_q;

  p_frozen_busy_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    (en && busy) |=> $stable(addr_q));

  p_step_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (en && !busy && !claim_q && !req[addr_q]) |=>
      (addr_q == (($past(addr_q) == LAST) ? '0 : $past(addr_q) + AW'(1))));

  p_hold_claim_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    (en && !busy && !claim_q && req[addr_q]) |=> $stable(addr_q));
endmodule

// File: rtl/arb_rank_grant.sv
module arb_rank_grant #(
  parameter int N_DEV = 4
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             en,
  input  logic             busy,
  input  logic [N_DEV-1:0] req,
  output logic [N_DEV-1:0] grant
);
  logic [N_DEV-1:0] grant_q, grant_d, pick;

  always_comb begin
    pick = '0;
    for (int i = N_DEV - 1; i >= 0; i--) begin
      if (req[i]) pick = N_DEV'(1) << i;
    end
  end

  always_comb begin
    if (!en || busy)          grant_d = '0;
    else if (grant_q == '0)   grant_d = pick;
    else                      grant_d = grant_q & req;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) grant_q <= '0;
    else         grant_q <= grant_d;
  end

  assign grant = grant_q;

  p_no_grant_busy_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    busy |=> (grant_q == '0));

  p_grant_follows_req_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    (en && !busy && grant_q == '0 && req != '0) |=> (grant_q != '0));
endmodule

// File: rtl/bus_arbiter.sv
module bus_arbiter
  import bus_arb_pkg::*;
#(
  parameter int N_DEV = 4,
  localparam int AW   = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_sel,
  input  logic [N_DEV-1:0] dev_req,
  input  logic             bus_busy,
  output logic [N_DEV-1:0] dev_grant,
  output logic [AW-1:0]    poll_addr,
  output logic             poll_valid
);
  logic    rst_meta, rst_sync;
  scheme_e mode_q, mode_d;
  logic    chain_en, scan_en, rank_en;
  logic [N_DEV-1:0] chain_grant, rank_grant;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  always_comb begin
    mode_d = mode_q;
    if (!rst_sync) mode_d = decode_scheme(mode_sel);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= SCH_CHAIN;
    else        mode_q <= mode_d;
  end

  assign chain_en = rst_sync && (mode_q == SCH_CHAIN);
  assign scan_en  = rst_sync && (mode_q == SCH_SCAN);
  assign rank_en  = rst_sync && (mode_q == SCH_RANK);

  arb_token_chain #(.N_DEV(N_DEV)) u_chain (
    .clk(clk), .rst_ni(rst_sync), .en(chain_en), .busy(bus_busy),
    .req(dev_req), .grant(chain_grant));

  arb_addr_scan #(.N_DEV(N_DEV)) u_scan (
    .clk(clk), .rst_ni(rst_sync), .en(scan_en), .busy(bus_busy),
    .req(dev_req), .addr(poll_addr), .valid(poll_valid));

  arb_rank_grant #(.N_DEV(N_DEV)) u_rank (
    .clk(clk), .rst_ni(rst_sync), .en(rank_en), .busy(bus_busy),
    .req(dev_req), .grant(rank_grant));

  assign dev_grant = chain_grant | rank_grant;

  p_one_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dev_grant));

  p_scan_no_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
    scan_en |-> (dev_grant == '0));

  p_mode_locked_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_sync) && rst_sync) |-> $stable(mode_q));

  p_reset_quiet_r10: assert property (@(posedge clk)
    !rst_sync |-> (dev_grant == '0 && !poll_valid));
endmodule

// File: tb/bus_arbiter_bench.sv
`timescale 1ns/1ps
module bus_arbiter_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] mode_sel;
  logic [3:0] dev_req;
  logic       bus_busy;
  logic [3:0] dev_grant;
  logic [1:0] poll_addr;
  logic       poll_valid;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bus_arbiter u_bus_arbiter (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .dev_req(dev_req),
    .bus_busy(bus_busy), .dev_grant(dev_grant), .poll_addr(poll_addr),
    .poll_valid(poll_valid));

  // chained-token vectors: {busy, req[3:0], expected grant[3:0]}
  localparam int NVEC = 10;
  localparam logic [8:0] VEC [NVEC] = '{
    {1'b0, 4'b0000, 4'b0000},
    {1'b0, 4'b1111, 4'b0001},
    {1'b0, 4'b1110, 4'b0010},
    {1'b0, 4'b1100, 4'b0100},
    {1'b0, 4'b1000, 4'b1000},
    {1'b0, 4'b1010, 4'b0010},
    {1'b1, 4'b1111, 4'b0000},
    {1'b1, 4'b0100, 4'b0000},
    {1'b0, 4'b0101, 4'b0001},
    {1'b0, 4'b0110, 4'b0010}
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] m);
    @(negedge clk);
    rst_n = 1'b0; mode_sel = m; dev_req = '0; bus_busy = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; mode_sel = 2'b01; dev_req = 4'b1111; bus_busy = 1'b0;
    repeat (3) @(negedge clk);
    // R10: outputs quiet during reset
    check("R10 grant in reset", dev_grant, 0);
    check("R10 valid in reset", poll_valid, 0);
    check("R10 addr in reset", poll_addr, 0);

    // chained token, vector walk (R2, R3, R9)
    do_reset(2'b00);
    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk);
      bus_busy = VEC[v][8];
      dev_req  = VEC[v][7:4];
      #1;
      check(VEC[v][8] ? "R3 chain busy" : "R2 chain rank", dev_grant, VEC[v][3:0]);
      check("R9 one grant", $countones(dev_grant) <= 1, 1);
    end
    // encoding 2'b11 also selects chained token (R1)
    do_reset(2'b11);
    @(negedge clk); dev_req = 4'b0100; #1;
    check("R1 code 11 chain", dev_grant, 4'b0100);

    // central ranking
    do_reset(2'b10);
    @(negedge clk);
    mode_sel = 2'b00; dev_req = 4'b0110; #1;
    check("R1 mode locked", dev_grant, 0);
    @(negedge clk);
    check("R4 rank grant", dev_grant, 4'b0010);
    bus_busy = 1'b1;
    @(negedge clk);
    check("R5 grant dropped", dev_grant, 0);
    dev_req = 4'b0101;
    repeat (3) @(negedge clk);
    check("R5 no grant busy", dev_grant, 0);
    bus_busy = 1'b0;
    @(negedge clk);
    check("R4 rank after busy", dev_grant, 4'b0001);
    bus_busy = 1'b1; dev_req = 4'b0000;
    @(negedge clk);
    bus_busy = 1'b0; dev_req = 4'b1000;
    @(negedge clk);
    check("R4 rank top device", dev_grant, 4'b1000);

    // address scan
    do_reset(2'b01);
    for (int k = 0; k < 6; k++) begin
      automatic logic [1:0] a = poll_addr;
      @(negedge clk);
      check("R6 scan step", poll_addr, 2'(a + 2'd1));
      check("R9 scan no grant", dev_grant, 0);
    end
    dev_req = 4'b0100;
    for (int k = 0; k < 8 && poll_addr != 2'd2; k++) @(negedge clk);
    repeat (3) @(negedge clk);
    check("R7 scan hold", poll_addr, 2);
    check("R7 scan valid", poll_valid, 1);
    bus_busy = 1'b1; #1;
    check("R8 valid low busy", poll_valid, 0);
    repeat (3) @(negedge clk);
    check("R8 addr frozen", poll_addr, 2);
    bus_busy = 1'b0; dev_req = 4'b0000;
    @(negedge clk);
    check("R8 resume next", poll_addr, 3);
    check("R8 valid again", poll_valid, 1);
    @(negedge clk);
    check("R6 scan wrap", poll_addr, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule